// File: doc/BRIEF.md
# Trigger Route Slot with Edge-to-Pulse Conversion

This block is a single output lane of a trigger crossbar. A 7-bit index chooses one line out of a wide trigger vector. The chosen line is then shaped before it leaves the block:

- In level mode it passes straight through.
- In edge modes a rising edge, a falling edge, or either edge becomes a single-clock pulse.

After shaping, an enable gate can force the result to its idle level, and an optional polarity flip is applied last. Everything lands in one output register, so the output is glitch-free and one clock behind its inputs.

Lines 0 and 1 of the vector are not wired to the input port. They are fixed at logic 0 and logic 1, so firmware always has a constant source available. An integrator instantiates one slot per destination and drives the configuration inputs from its own register file.

Edge detection compares the chosen line with a registered copy of itself. When the index changes, the comparison in that cycle would mix two different sources, so no pulse is issued in that cycle.

Top module: `trig_route_slot`

## Requirements
- R1: For an index of 2 or more, the selected source is `trig_in[cfg_sel]`, and no other input bit affects the output.
- R2: Index 0 reads as constant 0 and index 1 reads as constant 1, whatever values `trig_in[0]` and `trig_in[1]` carry.
- R3: With both `cfg_rise` and `cfg_fall` clear (level mode), `trig_out` equals the selected source as sampled at the previous clock edge.
- R4: With only `cfg_rise` set, a 0-to-1 change of the selected source between two consecutive samples gives exactly one cycle of active output. No other condition makes the output active.
- R5: With only `cfg_fall` set, a 1-to-0 change of the selected source gives exactly one cycle of active output. No other condition makes the output active.
- R6: With both `cfg_rise` and `cfg_fall` set, each change of the selected source in either direction gives a one-cycle active output.
- R7: When `cfg_inv` is 1, `trig_out` is the complement of the active value described in R3 to R6 (active is 1 before inversion).
- R8: When `out_en` is 0, the value before inversion is 0, so `trig_out` equals `cfg_inv` one cycle later, whatever the source does.
- R9: In an edge mode, a cycle in which `cfg_sel` differs from its value at the previous clock edge produces no pulse. After reset, the previous index counts as 0.
- R10: While `rst` is high, `trig_out` is 0 one cycle later. Reset also clears the registered copy of the source to 0 and the remembered index to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| trig_in | input | NUM_IN (128) | Trigger input vector; bits 0 and 1 are replaced by constants |
| cfg_sel | input | 7 | Index of the source line |
| cfg_inv | input | 1 | Flip output polarity |
| cfg_rise | input | 1 | Pulse on a rising edge of the source |
| cfg_fall | input | 1 | Pulse on a falling edge of the source |
| out_en | input | 1 | Output enable; when low the output sits at its idle level |
| trig_out | output | 1 | Registered, shaped trigger |

## Verification
Every result of this block is due one clock edge after the inputs that cause it:

- In level mode, the output follows the source sampled at the previous edge.
- In edge modes, a pulse appears after the edge at which the new source value is first sampled, and it is gone again after the next edge.
- Gating, inversion and the suppression on an index change also act in that same single edge.

The bench changes inputs only on the falling clock edge and reads `trig_out` on the following falling edge. Each check therefore sees exactly the one registered update caused by the vector applied half a period before the rising edge.

// File: rtl/trig_route_pkg.sv
package trig_route_pkg;

    localparam int TRIG_SEL_W = 7;

    typedef enum logic [1:0] {
        EDGE_NONE = 2'b00,
        EDGE_RISE = 2'b01,
        EDGE_FALL = 2'b10,
        EDGE_BOTH = 2'b11
    } edge_mode_e;

    typedef struct packed {
        logic [TRIG_SEL_W-1:0] sel;
        logic                  inv;
        edge_mode_e            mode;
        logic                  en;
    } slot_cfg_t;

    function automatic edge_mode_e make_mode(input logic rise, input logic fall);
        return edge_mode_e'({fall, rise});
    endfunction

    // Shaped value before gating and polarity, for one cycle.
    function automatic logic shape_value(input edge_mode_e mode,
                                         input logic cur,
                                         input logic last,
                                         input logic moved);
        logic r;
        unique case (mode)
            EDGE_NONE: r = cur;
            EDGE_RISE: r = cur & ~last & ~moved;
            EDGE_FALL: r = ~cur & last & ~moved;
            default:   r = (cur ^ last) & ~moved;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/trig_src_pick.sv
module trig_src_pick
    import trig_route_pkg::*;
#(
    parameter int NUM_IN = 128
) (
    input  logic [NUM_IN-1:0]     trig_in,
    input  logic [TRIG_SEL_W-1:0] sel,
    output logic                  src
);
    localparam int SPAN = 1 << TRIG_SEL_W;

    logic [SPAN-1:0] lines;
    logic            unused_tied;

    // Bits 0 and 1 of the port are overridden by constants.
    assign unused_tied = ^trig_in[1:0];

    for (genvar i = 0; i < SPAN; i++) begin : g_line
        if (i == 0) begin : g_zero
            assign lines[i] = 1'b0;
        end else if (i == 1) begin : g_one
            assign lines[i] = 1'b1;
        end else if (i < NUM_IN) begin : g_wire
            assign lines[i] = trig_in[i];
        end else begin : g_pad
            assign lines[i] = 1'b0;
        end
    end

    assign src = lines[sel];

endmodule

// File: rtl/trig_edge_track.sv
module trig_edge_track
    import trig_route_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  src,
    input  logic [TRIG_SEL_W-1:0] sel,
    input  edge_mode_e            mode,
    output logic                  shaped
);
    logic                  last_src;
    logic [TRIG_SEL_W-1:0] last_sel;
    logic                  moved;

    always_ff @(posedge clk) begin
        if (rst) begin
            last_src <= 1'b0;
            last_sel <= '0;
        end else begin
            last_src <= src;
            last_sel <= sel;
        end
    end

    assign moved  = (sel != last_sel);
    assign shaped = shape_value(mode, src, last_src, moved);

endmodule

// File: rtl/trig_out_reg.sv
module trig_out_reg (
    input  logic clk,
    input  logic rst,
    input  logic shaped,
    input  logic en,
    input  logic inv,
    output logic q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= 1'b0;
        end else begin
            q <= (en & shaped) ^ inv;
        end
    end
endmodule

// File: rtl/trig_route_slot.sv
module trig_route_slot
    import trig_route_pkg::*;
#(
    parameter int NUM_IN = 128
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NUM_IN-1:0]     trig_in,
    input  logic [TRIG_SEL_W-1:0] cfg_sel,
    input  logic                  cfg_inv,
    input  logic                  cfg_rise,
    input  logic                  cfg_fall,
    input  logic                  out_en,
    output logic                  trig_out
);
    slot_cfg_t cfg;
    logic      src;
    logic      shaped;

    always_comb begin
        cfg.sel  = cfg_sel;
        cfg.inv  = cfg_inv;
        cfg.mode = make_mode(cfg_rise, cfg_fall);
        cfg.en   = out_en;
    end

    trig_src_pick #(.NUM_IN(NUM_IN)) u_pick (
        .trig_in (trig_in),
        .sel     (cfg.sel),
        .src     (src)
    );

    trig_edge_track u_track (
        .clk    (clk),
        .rst    (rst),
        .src    (src),
        .sel    (cfg.sel),
        .mode   (cfg.mode),
        .shaped (shaped)
    );

    trig_out_reg u_oreg (
        .clk    (clk),
        .rst    (rst),
        .shaped (shaped),
        .en     (cfg.en),
        .inv    (cfg.inv),
        .q      (trig_out)
    );

endmodule

// File: rtl/trig_route_slot_chk.sv
module trig_route_slot_chk
    import trig_route_pkg::*;
#(
    parameter int NUM_IN = 128
) (
    input logic                  clk,
    input logic                  rst,
    input logic [NUM_IN-1:0]     trig_in,
    input logic [TRIG_SEL_W-1:0] cfg_sel,
    input logic                  cfg_inv,
    input logic                  cfg_rise,
    input logic                  cfg_fall,
    input logic                  out_en,
    input logic                  trig_out
);
    logic                  rst_d;
    logic                  valid;
    logic                  inv_d, rise_d, fall_d, en_d, src_d;
    logic [TRIG_SEL_W-1:0] sel_d, sel_dd;
    logic                  src_now;
    logic                  act;

    always_comb begin
        if (cfg_sel == 0)           src_now = 1'b0;
        else if (cfg_sel == 1)      src_now = 1'b1;
        else if (cfg_sel < NUM_IN)  src_now = trig_in[cfg_sel];
        else                        src_now = 1'b0;
    end

    always_ff @(posedge clk) rst_d <= rst;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid  <= 1'b0;
            inv_d  <= 1'b0;
            rise_d <= 1'b0;
            fall_d <= 1'b0;
            en_d   <= 1'b0;
            src_d  <= 1'b0;
            sel_d  <= '0;
            sel_dd <= '0;
        end else begin
            valid  <= 1'b1;
            inv_d  <= cfg_inv;
            rise_d <= cfg_rise;
            fall_d <= cfg_fall;
            en_d   <= out_en;
            src_d  <= src_now;
            sel_d  <= cfg_sel;
            sel_dd <= sel_d;
        end
    end

    assign act = trig_out ^ inv_d;

    AST_RESET_CLEAR: assert property (@(posedge clk) rst_d |-> !trig_out); // R10
    AST_GATE_IDLE: assert property (@(posedge clk) disable iff (rst) (valid && !en_d) |-> (trig_out == inv_d)); // R8
    AST_CONST_ZERO: assert property (@(posedge clk) disable iff (rst) (valid && en_d && sel_d == 0) |-> !act); // R2
    AST_PASS_LEVEL: assert property (@(posedge clk) disable iff (rst) (valid && en_d && !rise_d && !fall_d) |-> (act == src_d)); // R3
    AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (rst) (valid && en_d && rise_d && !fall_d && act) |=> (!(rise_d && !fall_d) || !act)); // R4
    AST_FALL_SINGLE: assert property (@(posedge clk) disable iff (rst) (valid && en_d && fall_d && !rise_d && act) |=> (!(fall_d && !rise_d) || !act)); // R5
    AST_SEL_QUIET: assert property (@(posedge clk) disable iff (rst) (valid && (rise_d || fall_d) && sel_d != sel_dd) |-> !act); // R9

endmodule

bind trig_route_slot trig_route_slot_chk #(.NUM_IN(NUM_IN)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .trig_in  (trig_in),
    .cfg_sel  (cfg_sel),
    .cfg_inv  (cfg_inv),
    .cfg_rise (cfg_rise),
    .cfg_fall (cfg_fall),
    .out_en   (out_en),
    .trig_out (trig_out)
);

// File: tb/sim_trig_route_slot.sv
module sim_trig_route_slot;
    localparam int NUM_IN = 128;
    localparam int ROWS   = 27;

    logic              clk = 1'b0;
    logic              rst;
    logic [NUM_IN-1:0] trig_in;
    logic [6:0]        cfg_sel;
    logic              cfg_inv, cfg_rise, cfg_fall, out_en;
    logic              trig_out;

    int  n_run  = 0;
    int  n_fail = 0;
    bit  done   = 0;

    // Row layout: {sel[6:0], inv, rise, fall, en, src, expected}
    localparam logic [12:0] TBL [0:ROWS-1] = '{
        {7'd5,   6'b000111},   // 0  R3 level high
        {7'd5,   6'b000100},   // 1  R3 level low
        {7'd5,   6'b010111},   // 2  R4 rise -> pulse
        {7'd5,   6'b010110},   // 3  R4 held high -> idle
        {7'd5,   6'b010100},   // 4  R4 fall ignored
        {7'd5,   6'b001100},   // 5  R5 low held
        {7'd5,   6'b001110},   // 6  R5 rise ignored
        {7'd5,   6'b001101},   // 7  R5 fall -> pulse
        {7'd5,   6'b011111},   // 8  R6 rise -> pulse
        {7'd5,   6'b011101},   // 9  R6 fall -> pulse
        {7'd5,   6'b011100},   // 10 R6 no change
        {7'd5,   6'b110110},   // 11 R7 inverted pulse
        {7'd5,   6'b110101},   // 12 R7 inverted idle
        {7'd9,   6'b010110},   // 13 R9 select moves, source 1
        {7'd9,   6'b010110},   // 14 R9 held
        {7'd9,   6'b010100},   // 15 R9 drop
        {7'd9,   6'b010111},   // 16 R9 genuine rise
        {7'd9,   6'b010000},   // 17 R8 gated
        {7'd9,   6'b010010},   // 18 R8 gated rise
        {7'd9,   6'b100011},   // 19 R8 gated + inverted
        {7'd9,   6'b000010},   // 20 R8 gated level
        {7'd1,   6'b000101},   // 21 R2 index 1 is one
        {7'd0,   6'b000110},   // 22 R2 index 0 is zero
        {7'd1,   6'b010100},   // 23 R2 const one, select moved
        {7'd1,   6'b010100},   // 24 R2 constant has no edge
        {7'd127, 6'b000111},   // 25 R1 top line high
        {7'd127, 6'b000100}    // 26 R1 top line low
    };

    function automatic string row_tag(input int k);
        if (k <= 1)  return "R3";
        if (k <= 4)  return "R4";
        if (k <= 7)  return "R5";
        if (k <= 10) return "R6";
        if (k <= 12) return "R7";
        if (k <= 16) return "R9";
        if (k <= 20) return "R8";
        if (k <= 24) return "R2";
        return "R1";
    endfunction

    always #5 clk = ~clk;

    trig_route_slot #(.NUM_IN(NUM_IN)) u0 (
        .clk      (clk),
        .rst      (rst),
        .trig_in  (trig_in),
        .cfg_sel  (cfg_sel),
        .cfg_inv  (cfg_inv),
        .cfg_rise (cfg_rise),
        .cfg_fall (cfg_fall),
        .out_en   (out_en),
        .trig_out (trig_out)
    );

    task automatic drive(input logic [6:0] sel, input logic inv, input logic rise,
                         input logic fall, input logic en, input logic src);
        cfg_sel  = sel;
        cfg_inv  = inv;
        cfg_rise = rise;
        cfg_fall = fall;
        out_en   = en;
        trig_in  = {NUM_IN{~src}};
        trig_in[sel] = src;
    endtask

    task automatic check(input string tag, input logic exp);
        n_run++;
        if (trig_out !== exp) begin
            n_fail++;
            $display("FAIL %s: trig_out=%b expected=%b at %0t", tag, trig_out, exp, $time);
        end
    endtask

    task automatic wrap_up;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    initial begin
        rst = 1'b1;
        drive(7'd1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1);
        repeat (3) @(negedge clk);
        check("R10 reset output", 1'b0);

        rst = 1'b0;
        for (int k = 0; k < ROWS; k++) begin
            drive(TBL[k][12:6], TBL[k][5], TBL[k][4], TBL[k][3], TBL[k][2], TBL[k][1]);
            @(negedge clk);
            check(row_tag(k), TBL[k][0]);
        end

        // R10: reset in mid-run, with an edge pending on the inputs
        drive(7'd9, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1);
        rst = 1'b1;
        @(negedge clk);
        check("R10 mid-run reset", 1'b0);
        rst = 1'b0;
        @(negedge clk);
        check("R10 R9 remembered index cleared to 0", 1'b0);
        drive(7'd9, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0);
        @(negedge clk);
        check("R4 falling side after reset", 1'b0);
        drive(7'd9, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1);
        @(negedge clk);
        check("R4 rise after reset", 1'b1);
        @(negedge clk);
        check("R4 pulse width", 1'b0);

        // R10: registered copy cleared, level-0 source gives no falling pulse
        drive(7'd7, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1);
        @(negedge clk);
        drive(7'd7, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        drive(7'd0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0);
        @(negedge clk);
        check("R10 copy cleared, no fall", 1'b0);

        done = 1;
        wrap_up();
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: run did not end, expected completion");
            wrap_up();
        end
    end

endmodule